// File: doc/BRIEF.md
# Receiver Electrical Idle Inference

This block decides that a receive lane has dropped into electrical idle without help from an analog squelch detector. It watches single-cycle strobes from the receive datapath and times how long the expected strobe stays absent. The link training state machine drives a 3-bit select code that says which strobe matters in the current training state and which window applies. When that window runs out with no qualifying strobe, the block raises a registered flag.

All windows are counted in block clock cycles. Millisecond windows use the `CLK_PER_MS` parameter. Unit-interval windows use the `UI_PER_CLK_G1` and `UI_PER_CLK_G2` parameters and are rounded up to whole cycles. This lets a simulation shorten every window by overriding three numbers.

The control path is a three-state machine:
- `ST_OFF`: inference is disabled and the counter is held clear.
- `ST_WATCH`: a window is being timed.
- `ST_INFERRED`: the flag is high.

Its transitions are:
- `OFF→WATCH` (select bit 2 rises).
- `WATCH→WATCH restart` (watched strobe, select change or rate change).
- `WATCH→INFERRED` (window expiry).
- `INFERRED→WATCH` (watched strobe, select change or rate change).
- `WATCH→OFF` and `INFERRED→OFF` (select bit 2 low).

Top module: `eidle_infer`

## Requirements
- R1: While `infer_sel[2]` is 0 (codes 3'b000 to 3'b011), `eidle_inferred` is 0 after the next clock edge, the window counter is held at zero, and the flag stays low no matter how long the code is held.
- R2: Code 3'b100 watches `com_skp_seen` and uses a window of 128*`CLK_PER_MS` cycles.
- R3: Code 3'b101 watches `ts_seen` and uses a window of ceil(1280/UI-per-clock) cycles at the current rate.
- R4: Code 3'b110 watches `eidle_exit_seen`. Its window is ceil(2000/`UI_PER_CLK_G1`) cycles at Gen1 and ceil(16000/`UI_PER_CLK_G2`) cycles at Gen2.
- R5: Code 3'b111 watches `eidle_exit_seen` and uses a window of 128*`CLK_PER_MS` cycles at every rate.
- R6: `link_rate` 2'b00 selects Gen1. Every other value (2'b01 for Gen2, and the unused codes) uses the Gen2 unit-interval lengths.
- R7: Counting from a restart edge, `eidle_inferred` rises at the W-th following clock edge, where W is the window. This holds only if the watched strobe stays low and the select and rate codes stay unchanged at each of those edges. The flag is still low after edge W-1.
- R8: A watched strobe sampled at an edge clears `eidle_inferred` at that edge and restarts the window from zero.
- R9: Strobes other than the watched one have no effect on the counter or the flag.
- R10: A change of `infer_sel` or `link_rate` while inference is enabled restarts the window from zero and clears the flag.
- R11: Once high, `eidle_inferred` stays high until the watched strobe arrives, the select or rate code changes, or `infer_sel[2]` goes low.
- R12: Synchronous active-high `rst` clears the flag and the counter at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| infer_sel | input | 3 | Inference select code from the training state machine |
| link_rate | input | 2 | Rate code: 2'b00 Gen1, otherwise Gen2 |
| com_skp_seen | input | 1 | One-cycle strobe: COM/SKP ordered set received |
| ts_seen | input | 1 | One-cycle strobe: TS1/TS2 ordered set received |
| eidle_exit_seen | input | 1 | One-cycle strobe: electrical idle exit detected |
| eidle_inferred | output | 1 | Registered electrical idle inferred flag |

## Verification
The embedded properties check these rules on every cycle:
- A disabled select code forces the flag low and the counter to zero.
- A watched strobe clears the flag.
- The flag never rises unless the counter sat at its limit on the prior cycle.
- The flag holds while nothing restarts it.
- The counter either clears or advances by exactly one.

Only the bench scenarios can show the rest:
- The exact window length for each select and rate pair, including the rate-independent 128 ms modes and the unused rate codes.
- That the non-watched strobes are ignored.
- That a mid-window rate or select change measures a fresh window from the change.

// File: rtl/eidle_infer_pkg.sv
package eidle_infer_pkg;

    typedef enum logic [1:0] {
        ST_OFF      = 2'd0,
        ST_WATCH    = 2'd1,
        ST_INFERRED = 2'd2
    } infer_state_e;

    // Rate code 2'b00 is Gen1; anything else takes the Gen2 lengths.
    function automatic logic rate_is_gen1(input logic [1:0] rate);
        return (rate == 2'b00);
    endfunction

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eidle_event_mux.sv
module eidle_event_mux (
    input  logic [2:0] sel,
    input  logic       com_skp_seen,
    input  logic       ts_seen,
    input  logic       eidle_exit_seen,
    output logic       watched_evt
);
    always_comb begin
        unique case (sel)
            3'b100:         watched_evt = com_skp_seen;
            3'b101:         watched_evt = ts_seen;
            3'b110, 3'b111: watched_evt = eidle_exit_seen;
            default:        watched_evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/eidle_window_sel.sv
module eidle_window_sel
    import eidle_infer_pkg::*;
#(
    parameter int CLK_PER_MS    = 250000,
    parameter int UI_PER_CLK_G1 = 10,
    parameter int UI_PER_CLK_G2 = 20,
    parameter int CNT_W         = 26
) (
    input  logic [2:0]       sel,
    input  logic [1:0]       rate,
    output logic [CNT_W-1:0] win_len
);
    localparam int WIN_MS128   = 128 * CLK_PER_MS;
    localparam int WIN_TS_G1   = ceil_div(1280, UI_PER_CLK_G1);
    localparam int WIN_TS_G2   = ceil_div(1280, UI_PER_CLK_G2);
    localparam int WIN_EXIT_G1 = ceil_div(2000, UI_PER_CLK_G1);
    localparam int WIN_EXIT_G2 = ceil_div(16000, UI_PER_CLK_G2);

    logic gen1;
    assign gen1 = rate_is_gen1(rate);

    always_comb begin
        unique case (sel)
            3'b100:  win_len = CNT_W'(WIN_MS128);
            3'b101:  win_len = gen1 ? CNT_W'(WIN_TS_G1) : CNT_W'(WIN_TS_G2);
            3'b110:  win_len = gen1 ? CNT_W'(WIN_EXIT_G1) : CNT_W'(WIN_EXIT_G2);
            3'b111:  win_len = CNT_W'(WIN_MS128);
            default: win_len = CNT_W'(1);
        endcase
    end
endmodule

// File: rtl/eidle_window_timer.sv
module eidle_window_timer #(
    parameter int CNT_W = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic [CNT_W-1:0] win_len,
    output logic [CNT_W-1:0] cnt_o,
    output logic             at_limit
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_o <= '0;
        end else if (run) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    assign at_limit = (cnt_o == win_len - 1'b1);

    // R10: a clear request empties the counter at the next edge.
    assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_o == '0));

    // R7: a running window advances by exactly one per cycle.
    assert_count_R7: assert property (@(posedge clk) disable iff (rst)
        (run && !clr) |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/eidle_infer.sv
module eidle_infer
    import eidle_infer_pkg::*;
#(
    parameter int CLK_PER_MS    = 250000,
    parameter int UI_PER_CLK_G1 = 10,
    parameter int UI_PER_CLK_G2 = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] infer_sel,
    input  logic [1:0] link_rate,
    input  logic       com_skp_seen,
    input  logic       ts_seen,
    input  logic       eidle_exit_seen,
    output logic       eidle_inferred
);
    localparam int LONGEST = max2(128 * CLK_PER_MS,
                             max2(ceil_div(16000, UI_PER_CLK_G2),
                             max2(ceil_div(2000, UI_PER_CLK_G1),
                                  ceil_div(1280, UI_PER_CLK_G1))));
    localparam int CNT_W = $clog2(LONGEST + 1);

    infer_state_e     state_q, state_d;
    logic [2:0]       sel_q;
    logic [1:0]       rate_q;
    logic             watched_evt;
    logic             restart;
    logic             enabled;
    logic             tmr_clr;
    logic             tmr_run;
    logic             at_limit;
    logic [CNT_W-1:0] win_len;
    logic [CNT_W-1:0] cnt;

    eidle_event_mux u_evt (
        .sel             (infer_sel),
        .com_skp_seen    (com_skp_seen),
        .ts_seen         (ts_seen),
        .eidle_exit_seen (eidle_exit_seen),
        .watched_evt     (watched_evt)
    );

    eidle_window_sel #(
        .CLK_PER_MS    (CLK_PER_MS),
        .UI_PER_CLK_G1 (UI_PER_CLK_G1),
        .UI_PER_CLK_G2 (UI_PER_CLK_G2),
        .CNT_W         (CNT_W)
    ) u_win (
        .sel     (infer_sel),
        .rate    (link_rate),
        .win_len (win_len)
    );

    eidle_window_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .clr      (tmr_clr),
        .run      (tmr_run),
        .win_len  (win_len),
        .cnt_o    (cnt),
        .at_limit (at_limit)
    );

    assign enabled = infer_sel[2];
    assign restart = watched_evt || (infer_sel != sel_q) || (link_rate != rate_q);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (enabled) state_d = ST_WATCH;
            end
            ST_WATCH: begin
                if (!enabled)      state_d = ST_OFF;
                else if (restart)  state_d = ST_WATCH;
                else if (at_limit) state_d = ST_INFERRED;
            end
            ST_INFERRED: begin
                if (!enabled)     state_d = ST_OFF;
                else if (restart) state_d = ST_WATCH;
            end
            default: state_d = ST_OFF;
        endcase
    end

    assign tmr_clr = (state_q == ST_OFF) || !enabled || restart;
    assign tmr_run = (state_q == ST_WATCH) && !tmr_clr && !at_limit;

    // State register and code history.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
            sel_q   <= 3'b000;
            rate_q  <= 2'b00;
        end else begin
            state_q <= state_d;
            sel_q   <= infer_sel;
            rate_q  <= link_rate;
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (rst) eidle_inferred <= 1'b0;
        else     eidle_inferred <= (state_d == ST_INFERRED);
    end

    // R1: a disabled code forces the flag low and the counter clear.
    assert_off_R1: assert property (@(posedge clk) disable iff (rst)
        !infer_sel[2] |=> (!eidle_inferred && cnt == '0));

    // R8: a watched strobe drops the flag.
    assert_event_R8: assert property (@(posedge clk) disable iff (rst)
        (infer_sel[2] && watched_evt) |=> !eidle_inferred);

    // R7: the flag rises only after the counter reached its limit.
    assert_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(eidle_inferred) |-> $past(at_limit));

    // R11: with nothing restarting it, the flag holds.
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (eidle_inferred && infer_sel[2] && !watched_evt &&
         infer_sel == sel_q && link_rate == rate_q) |=> eidle_inferred);
endmodule

// File: tb/tb_eidle_infer.sv
module tb_eidle_infer;
    localparam int CPM = 4;   // 128 ms window = 512 cycles
    localparam int G1  = 40;  // 1280 UI = 32, 2000 UI = 50
    localparam int G2  = 80;  // 1280 UI = 16, 16000 UI = 200

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] infer_sel = 3'b000;
    logic [1:0] link_rate = 2'b00;
    logic       com_skp_seen = 1'b0;
    logic       ts_seen = 1'b0;
    logic       eidle_exit_seen = 1'b0;
    logic       eidle_inferred;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    eidle_infer #(.CLK_PER_MS(CPM), .UI_PER_CLK_G1(G1), .UI_PER_CLK_G2(G2)) dut (
        .clk(clk), .rst(rst), .infer_sel(infer_sel), .link_rate(link_rate),
        .com_skp_seen(com_skp_seen), .ts_seen(ts_seen),
        .eidle_exit_seen(eidle_exit_seen), .eidle_inferred(eidle_inferred)
    );

    // {sel, rate, window cycles, requirement index}
    localparam int NV = 10;
    localparam logic [24:0] VEC [NV] = '{
        {3'b100, 2'b00, 16'd512, 4'd2},
        {3'b100, 2'b01, 16'd512, 4'd2},
        {3'b101, 2'b00, 16'd32,  4'd3},
        {3'b101, 2'b01, 16'd16,  4'd3},
        {3'b110, 2'b00, 16'd50,  4'd4},
        {3'b110, 2'b01, 16'd200, 4'd4},
        {3'b111, 2'b00, 16'd512, 4'd5},
        {3'b111, 2'b01, 16'd512, 4'd5},
        {3'b101, 2'b10, 16'd16,  4'd6},
        {3'b110, 2'b11, 16'd200, 4'd6}
    };

    task automatic check(input logic got, input logic exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: eidle_inferred=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // At a negedge: set codes, pulse all strobes once (restart edge k).
    task automatic restart_with(input logic [2:0] s, input logic [1:0] r);
        infer_sel = s; link_rate = r;
        com_skp_seen = 1'b1; ts_seen = 1'b1; eidle_exit_seen = 1'b1;
        @(negedge clk);
        com_skp_seen = 1'b0; ts_seen = 1'b0; eidle_exit_seen = 1'b0;
    endtask

    // Called just after restart edge k; checks low after k+w-1, high after k+w.
    task automatic measure(input int w, input string req);
        repeat (w - 1) @(negedge clk);
        check(eidle_inferred, 1'b0, req);
        @(negedge clk);
        check(eidle_inferred, 1'b1, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(eidle_inferred, 1'b0, "R12 reset");
        rst = 1'b0;
        @(negedge clk);

        // R1: disabled codes keep the flag low over a long hold.
        infer_sel = 3'b010;
        com_skp_seen = 1'b0;
        repeat (600) @(negedge clk);
        check(eidle_inferred, 1'b0, "R1 disabled hold");

        // Table walk: R2 R3 R4 R5 R6 R7.
        for (int i = 0; i < NV; i++) begin
            restart_with(VEC[i][24:22], VEC[i][21:20]);
            measure(int'(VEC[i][19:4]), $sformatf("R7/R%0d vec %0d", VEC[i][3:0], i));
        end

        // R11: flag holds while nothing restarts it.
        restart_with(3'b101, 2'b00);
        measure(32, "R3 gen1 ts");
        repeat (300) @(negedge clk);
        check(eidle_inferred, 1'b1, "R11 hold");

        // R8: watched strobe clears, then fresh window.
        ts_seen = 1'b1;
        @(negedge clk);
        ts_seen = 1'b0;
        check(eidle_inferred, 1'b0, "R8 clear");
        measure(32, "R8 new window");

        // R9: other strobes ignored while timing mode 101.
        restart_with(3'b101, 2'b00);
        repeat (9) @(negedge clk);
        com_skp_seen = 1'b1; eidle_exit_seen = 1'b1;
        @(negedge clk);
        com_skp_seen = 1'b0; eidle_exit_seen = 1'b0;
        measure(22, "R9 unwatched strobes");
        com_skp_seen = 1'b1; eidle_exit_seen = 1'b1;
        @(negedge clk);
        com_skp_seen = 1'b0; eidle_exit_seen = 1'b0;
        check(eidle_inferred, 1'b1, "R9 flag kept");

        // R10: rate change mid-window restarts with Gen2 length.
        restart_with(3'b110, 2'b00);
        repeat (40) @(negedge clk);
        link_rate = 2'b01;
        @(negedge clk);
        measure(200, "R10 rate change");

        // R10: select change while inferred clears and restarts.
        infer_sel = 3'b101;
        @(negedge clk);
        check(eidle_inferred, 1'b0, "R10 sel change clears");
        measure(16, "R10 sel change window");

        // R1: going to a disabled code drops the flag.
        infer_sel = 3'b011;
        @(negedge clk);
        check(eidle_inferred, 1'b0, "R1 disable drops flag");

        // R12: reset while inferred.
        restart_with(3'b101, 2'b01);
        measure(16, "R3 gen2 ts");
        rst = 1'b1;
        @(negedge clk);
        check(eidle_inferred, 1'b0, "R12 reset clears");
        rst = 1'b0;

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule